// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. Software writes a control word, which sets a clock divider and an enable bit, and an access word, which holds a start flag, a direction flag, a 5-bit PHY address, a 5-bit register address and 16 data bits. While the block is enabled, setting the start flag launches one Clause 22 transaction. The block derives the management clock from the system clock. It sends 32 preamble ones and then a 32-bit frame, most significant bit first. On reads it releases the data line so that the PHY can drive it.

When the transaction finishes, the hardware clears the start flag. A read also leaves the returned 16 bits in the access word, together with a flag that says whether the PHY pulled the line low in the second turnaround bit. A status bit in the control word reads 1 whenever no transaction is running. Clearing the enable bit never cuts a frame short: the current frame runs to its end, and the block then stays quiet.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 32'h8000_0000, the access word reads 0, and `mdc` and `mdio_oe` are low.
- R2: Control word layout: bits 15:0 are the divider, bit 30 is the enable and bit 31 is the read-only idle flag. The idle flag is 1 exactly when no transaction is in progress. The divider and enable read back as written.
- R3: During a transaction `mdc` has a period of divider+1 system clocks, and a divider of 0 acts as 1. Each period starts with floor((divider+1)/2) low cycles and ends with the remaining high cycles. The divider is taken at the start of each transaction. While idle, `mdc` and `mdio_oe` stay low.
- R4: A write sends 32 ones, then 01, then opcode 01, PHY address, register address, turnaround 10 and data, all MSB first. Bit 0 is the first preamble bit. `mdio_o` changes only when `mdc` falls.
- R5: A read sends opcode 10. `mdio_oe` is high for bits 0 to 45 and low for bits 46 to 63. On writes `mdio_oe` stays high for the whole transaction.
- R6: At the end of a read, access bit 29 is 1 only if `mdio_i` was low at the rising `mdc` edge of bit 47. Bits 15:0 then hold the 16 bits sampled at the rising edges of bits 48 to 63, first sample in bit 15.
- R7: The transaction starts on the clock after the start flag is set. It ends 64 `mdc` periods later, and the start flag (bit 31) clears on that same edge.
- R8: No transaction starts while the enable bit is 0. A set start flag stays pending and `mdc` stays still until the block is enabled.
- R9: Clearing the enable bit in mid-frame does not shorten the frame: all 64 bits are sent, and the idle flag then reads 1.
- R10: A write to the access word while its start flag reads 1 is ignored, including a write in the very cycle the transaction completes.
- R11: Access word layout: bit 31 is start, bit 30 selects write (1) or read (0), bit 29 is the acknowledge flag, bits 25:21 are the register address, bits 20:16 the PHY address and bits 15:0 the data. Bits 28:26 read 0. An accepted write clears bit 29. A completed write leaves bit 29 at 0 and the data field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control word, 1 access word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the management data pad |
| mdio_i | input | 1 | Management data in |

## Verification
Two events can meet on one clock edge: the completion of a transaction, which clears the start flag and stores the read result, and a software write to the access word. The bench counts clocks from the start of a read and places a new access write on exactly the edge where the 64th period ends. It then reads the access word and expects the finished read: start flag clear, acknowledge set and the returned data. The new pattern must not appear. The same rule is also tested against a write made in mid-frame, by checking the PHY address that appears in the serial frame.

// File: rtl/mdio_pkg.sv
// Package: shared constants, register field positions and the frame builder
// for the MDIO management master. Assumes Clause 22 framing only.
package mdio_pkg;
    localparam int PRE_LEN  = 32;                 // preamble ones
    localparam int FRM_LEN  = 32;                 // management frame bits
    localparam int TOT_LEN  = PRE_LEN + FRM_LEN;  // bits per transaction
    localparam int IDX_W    = $clog2(TOT_LEN);
    localparam int DIV_W    = 16;
    localparam int ADR_W    = 5;
    localparam int DAT_W    = 16;
    localparam int TA1_IDX  = PRE_LEN + 14;       // first turnaround bit
    localparam int TA2_IDX  = PRE_LEN + 15;       // second turnaround bit
    localparam int DAT0_IDX = PRE_LEN + 16;       // first data bit

    // field positions of the two software-visible words
    localparam int CTL_IDLE = 31;
    localparam int CTL_EN   = 30;
    localparam int ACC_GO   = 31;
    localparam int ACC_WR   = 30;
    localparam int ACC_ACK  = 29;
    localparam int ACC_REG  = 21;
    localparam int ACC_PHY  = 16;

    typedef enum logic {SEL_CTRL = 1'b0, SEL_ACCESS = 1'b1} reg_sel_e;

    // Builds the whole serial pattern, MSB sent first.
    function automatic logic [TOT_LEN-1:0] build_frame(
        input logic             wr,
        input logic [ADR_W-1:0] phy,
        input logic [ADR_W-1:0] ra,
        input logic [DAT_W-1:0] d);
        return {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
                (wr ? 2'b10 : 2'b11), (wr ? d : {DAT_W{1'b1}})};
    endfunction
endpackage

// File: rtl/mdio_clk_div.sv
// Clock divider: produces mdc with a period of div+1 system clocks (div 0
// treated as 1), low half first, plus strobes that mark the system-clock
// edge on which mdc rises or falls. Assumes run is held for whole frames.
module mdio_clk_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half;

    // latch the divider at transaction start, clamping zero to one
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= DIV_W'(1);
        else if (load)
            div_q <= (div_in == '0) ? DIV_W'(1) : div_in;
    end

    // phase counter, parked at zero when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (cnt_q == div_q)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // low phase length = floor((div+1)/2)
    always_comb half = (div_q >> 1) + {{(DIV_W-1){1'b0}}, div_q[0]};

    assign mdc      = run && (cnt_q >= half);
    assign rise_evt = run && (cnt_q == half - 1'b1);
    assign fall_evt = run && (cnt_q == div_q);
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: shifts out preamble and frame on mdc falling strobes,
// samples turnaround and read data on rising strobes, and releases the
// output enable for the reply part of a read. Assumes start only when idle.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [ADR_W-1:0] phy,
    input  logic [ADR_W-1:0] ra,
    input  logic [DAT_W-1:0] wdata,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic [DAT_W-1:0] rd_data,
    output logic             ack
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TOT_LEN - 1);
    localparam logic [IDX_W-1:0] TA1  = IDX_W'(TA1_IDX);
    localparam logic [IDX_W-1:0] TA2  = IDX_W'(TA2_IDX);
    localparam logic [IDX_W-1:0] DAT0 = IDX_W'(DAT0_IDX);

    logic               busy_q;
    logic               wr_q;
    logic [IDX_W-1:0]   bit_q;
    logic [TOT_LEN-1:0] shreg_q;
    logic [DAT_W-1:0]   rx_q;
    logic               ack_q;

    assign done = busy_q && fall_evt && (bit_q == LAST);

    // sequencing: load on start, advance one bit per mdc falling strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            wr_q    <= 1'b0;
            bit_q   <= '0;
            shreg_q <= '1;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            wr_q    <= is_write;
            bit_q   <= '0;
            shreg_q <= build_frame(is_write, phy, ra, wdata);
        end else if (busy_q && fall_evt) begin
            if (bit_q == LAST)
                busy_q <= 1'b0;
            else
                bit_q <= bit_q + 1'b1;
            shreg_q <= {shreg_q[TOT_LEN-2:0], 1'b1};
        end
    end

    // capture turnaround acknowledge and reply data on mdc rising strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q  <= '0;
            ack_q <= 1'b0;
        end else if (start && !busy_q) begin
            ack_q <= 1'b0;
        end else if (busy_q && rise_evt && !wr_q) begin
            if (bit_q == TA2)
                ack_q <= !mdio_i;
            if (bit_q >= DAT0)
                rx_q <= {rx_q[DAT_W-2:0], mdio_i};
        end
    end

    assign busy    = busy_q;
    assign mdio_o  = busy_q ? shreg_q[TOT_LEN-1] : 1'b1;
    assign mdio_oe = busy_q && (wr_q || (bit_q < TA1));
    assign rd_data = rx_q;
    assign ack     = ack_q;
endmodule

// File: rtl/mdio_master.sv
// MDIO management master top: holds the control and access words, starts a
// transaction when the go flag is set and the block is enabled, and writes
// the result back on completion. Assumes one register access per clock.
module mdio_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0] div_q;
    logic             en_q;
    logic             go_q;
    logic             acc_wr_q;
    logic             ack_bit_q;
    logic [ADR_W-1:0] regad_q;
    logic [ADR_W-1:0] phy_q;
    logic [DAT_W-1:0] data_q;

    logic             busy;
    logic             done;
    logic             start;
    logic             rise_evt;
    logic             fall_evt;
    logic [DAT_W-1:0] rd_data;
    logic             eng_ack;
    logic             wr_ctrl;
    logic             wr_acc;

    assign start   = go_q && en_q && !busy;
    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_acc  = reg_wr && (reg_sel == SEL_ACCESS) && !go_q;

    // control word: divider and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            en_q  <= 1'b0;
        end else if (wr_ctrl) begin
            div_q <= reg_wdata[DIV_W-1:0];
            en_q  <= reg_wdata[CTL_EN];
        end
    end

    // access word: software load when not pending, hardware write-back on done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q      <= 1'b0;
            acc_wr_q  <= 1'b0;
            ack_bit_q <= 1'b0;
            regad_q   <= '0;
            phy_q     <= '0;
            data_q    <= '0;
        end else if (wr_acc) begin
            go_q      <= reg_wdata[ACC_GO];
            acc_wr_q  <= reg_wdata[ACC_WR];
            ack_bit_q <= 1'b0;
            regad_q   <= reg_wdata[ACC_REG +: ADR_W];
            phy_q     <= reg_wdata[ACC_PHY +: ADR_W];
            data_q    <= reg_wdata[DAT_W-1:0];
        end else if (done) begin
            go_q <= 1'b0;
            if (!acc_wr_q) begin
                data_q    <= rd_data;
                ack_bit_q <= eng_ack;
            end
        end
    end

    // read mux for the two words
    always_comb begin
        if (reg_sel == SEL_CTRL)
            reg_rdata = {!busy, en_q, {(30-DIV_W){1'b0}}, div_q};
        else
            reg_rdata = {go_q, acc_wr_q, ack_bit_q, 3'b000, regad_q, phy_q, data_q};
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .div_in   (div_q),
        .run      (busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (acc_wr_q),
        .phy      (phy_q),
        .ra       (regad_q),
        .wdata    (data_q),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data),
        .ack      (eng_ack)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Checker: temporal properties of the MDIO master, bound to its top.
// Assumes synchronous active-low reset.
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             go_q,
    input logic             en_q,
    input logic             acc_wr_q,
    input logic             done,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [ADR_W-1:0] phy_q,
    input logic [ADR_W-1:0] regad_q
);
    // R3: bus clock and drive quiet while idle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R4: data out changes only together with a falling mdc
    p_out_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

    // R5: output enable is dropped in mid-frame only for reads
    p_oe_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(mdio_oe)) |-> !acc_wr_q);

    // R7: go flag clears only on a completion edge
    p_go_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(go_q) |-> $past(done));

    // R8: a transaction starts only while enabled and requested
    p_start_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(en_q) && $past(go_q)));

    // R10: access writes while pending leave the addresses untouched
    p_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go_q && reg_wr && reg_sel) |=> ($stable(phy_q) && $stable(regad_q)));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .go_q     (go_q),
    .en_q     (en_q),
    .acc_wr_q (acc_wr_q),
    .done     (done),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .phy_q    (phy_q),
    .regad_q  (regad_q)
);

// File: tb/mdio_master_tb.sv
// Directed bench for the MDIO master with a small PHY model on the bus pins.
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // PHY model state
    int          rise_cnt = 0;
    int          last_rise = 0;
    int          meas_per = 0;
    int          meas_high = 0;
    logic [63:0] cap;
    logic [63:0] oecap;
    logic        phy_resp = 1'b0;
    logic [15:0] phy_val = '0;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc++;

    // bus monitor: capture pins at each mdc rise
    always @(posedge mdc) begin
        #1;
        if (rise_cnt > 0) meas_per = cyc - last_rise;
        last_rise = cyc;
        if (rise_cnt < 64) begin
            cap[63-rise_cnt]   = mdio_o;
            oecap[63-rise_cnt] = mdio_oe;
        end
        rise_cnt++;
    end

    // PHY reply: drive the next bit after each mdc fall
    always @(negedge mdc) begin
        #1;
        meas_high = cyc - last_rise;
        if (rise_cnt == 47)
            mdio_i = !phy_resp;
        else if (phy_resp && rise_cnt >= 48 && rise_cnt < 64)
            mdio_i = phy_val[63-rise_cnt];
        else
            mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    function automatic logic [31:0] acc_word(input logic go, input logic wr,
        input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        return {go, wr, 4'b0000, ra, phy, d};
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr,
        input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra,
                (wr ? 2'b10 : 2'b11), (wr ? d : 16'hFFFF)};
    endfunction

    // poll until the go flag reads 0; k counts negedges after the issue edge
    task automatic wait_go_clear(output int k);
        k = 0;
        reg_sel = 1'b1;
        forever begin
            @(negedge clk);
            #1;
            if (!reg_rdata[31] || k > 70000) break;
            k++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_read(1'b0, v); chk(v == 32'h8000_0000, "R1", v, 32'h8000_0000, "control after reset");
        reg_read(1'b1, v); chk(v == 0, "R1", v, 0, "access after reset");
        chk(!mdc && !mdio_oe, "R1", {mdc, mdio_oe}, 0, "bus pins after reset");
    endtask

    task automatic t_ctrl_rw;
        logic [31:0] v;
        reg_write(1'b0, 32'h4000_0003);
        reg_read(1'b0, v); chk(v == 32'hC000_0003, "R2", v, 32'hC000_0003, "control readback");
    endtask

    task automatic t_write_frame;
        logic [31:0] v;
        int k;
        rise_cnt = 0; phy_resp = 1'b0;
        reg_write(1'b1, acc_word(1'b1, 1'b1, 5'd5, 5'h12, 16'hBEEF));
        wait_go_clear(k);
        chk(k == 257, "R7", k, 257, "cycles until go clears");
        chk(cap == exp_frame(1'b1, 5'd5, 5'h12, 16'hBEEF), "R4", cap,
            exp_frame(1'b1, 5'd5, 5'h12, 16'hBEEF), "write frame");
        chk(oecap == '1, "R5", oecap, '1, "oe during write");
        chk(meas_per == 4, "R3", meas_per, 4, "mdc period div 3");
        chk(meas_high == 2, "R3", meas_high, 2, "mdc high time div 3");
        reg_read(1'b1, v);
        chk(v == acc_word(1'b0, 1'b1, 5'd5, 5'h12, 16'hBEEF), "R11", v,
            acc_word(1'b0, 1'b1, 5'd5, 5'h12, 16'hBEEF), "access after write");
        chk(!mdc && !mdio_oe, "R3", {mdc, mdio_oe}, 0, "idle pins");
    endtask

    task automatic t_read(input logic resp, input logic [15:0] val);
        logic [31:0] v;
        logic [31:0] ex;
        int k;
        rise_cnt = 0; phy_resp = resp; phy_val = val;
        reg_write(1'b1, acc_word(1'b1, 1'b0, 5'd17, 5'd2, 16'h0000));
        wait_go_clear(k);
        chk(cap[63:18] == exp_frame(1'b0, 5'd17, 5'd2, 16'h0)[63:18], "R5",
            cap[63:18], exp_frame(1'b0, 5'd17, 5'd2, 16'h0)[63:18], "read header");
        chk(oecap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5", oecap,
            {46'h3FFF_FFFF_FFFF, 18'h0}, "oe release on read");
        reg_read(1'b1, v);
        ex = {1'b0, 1'b0, resp, 3'b000, 5'd2, 5'd17, (resp ? val : 16'hFFFF)};
        chk(v == ex, "R6", v, ex, resp ? "read with ack" : "read without ack");
    endtask

    task automatic t_div(input logic [15:0] d, input int per, input int hi);
        int k;
        reg_write(1'b0, {16'h4000, d});
        rise_cnt = 0; phy_resp = 1'b0;
        reg_write(1'b1, acc_word(1'b1, 1'b1, 5'd1, 5'd1, 16'h0F0F));
        wait_go_clear(k);
        chk(meas_per == per, "R3", meas_per, per, "mdc period");
        chk(meas_high == hi, "R3", meas_high, hi, "mdc high time");
        chk(rise_cnt == 64, "R3", rise_cnt, 64, "mdc periods per transaction");
    endtask

    task automatic t_enable_gate;
        logic [31:0] v;
        int k;
        reg_write(1'b0, 32'h0000_0003);
        rise_cnt = 0;
        reg_write(1'b1, acc_word(1'b1, 1'b1, 5'd2, 5'd4, 16'h5555));
        repeat (40) @(posedge clk);
        chk(rise_cnt == 0, "R8", rise_cnt, 0, "no mdc while disabled");
        reg_read(1'b1, v); chk(v[31], "R8", v[31], 1, "go pending while disabled");
        reg_read(1'b0, v); chk(v[31], "R8", v[31], 1, "idle while disabled");
        reg_write(1'b0, 32'h4000_0003);
        wait_go_clear(k);
        chk(rise_cnt == 64, "R8", rise_cnt, 64, "runs after enable");
    endtask

    task automatic t_disable_mid;
        logic [31:0] v;
        int k;
        reg_write(1'b0, 32'h4000_0003);
        rise_cnt = 0;
        reg_write(1'b1, acc_word(1'b1, 1'b1, 5'd9, 5'd3, 16'h1234));
        repeat (40) @(posedge clk);
        reg_write(1'b0, 32'h0000_0003);
        reg_read(1'b0, v); chk(!v[31], "R9", v[31], 0, "still busy after disable");
        reg_write(1'b1, acc_word(1'b1, 1'b0, 5'h1F, 5'h1F, 16'hFFFF));
        wait_go_clear(k);
        chk(rise_cnt == 64, "R9", rise_cnt, 64, "frame completes after disable");
        chk(cap == exp_frame(1'b1, 5'd9, 5'd3, 16'h1234), "R10", cap,
            exp_frame(1'b1, 5'd9, 5'd3, 16'h1234), "mid-frame write ignored");
        reg_read(1'b0, v); chk(v == 32'h8000_0003, "R9", v, 32'h8000_0003, "idle after drain");
        reg_write(1'b0, 32'h4000_0003);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        logic [31:0] ex;
        rise_cnt = 0; phy_resp = 1'b1; phy_val = 16'h3C5A;
        reg_write(1'b1, acc_word(1'b1, 1'b0, 5'd6, 5'd7, 16'h0000));
        repeat (64 * 4) @(posedge clk);
        reg_write(1'b1, acc_word(1'b0, 1'b1, 5'd30, 5'd29, 16'hDEAD));
        reg_read(1'b1, v);
        ex = {1'b0, 1'b0, 1'b1, 3'b000, 5'd7, 5'd6, 16'h3C5A};
        chk(v == ex, "R10", v, ex, "write on completion edge ignored");
        reg_write(1'b1, acc_word(1'b0, 1'b1, 5'd30, 5'd29, 16'hDEAD));
        reg_read(1'b1, v);
        ex = acc_word(1'b0, 1'b1, 5'd30, 5'd29, 16'hDEAD);
        chk(v == ex, "R11", v, ex, "write after completion accepted, ack cleared");
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ctrl_rw();
        t_write_frame();
        t_read(1'b1, 16'hA5C3);
        t_read(1'b0, 16'h0000);
        t_div(16'd4, 5, 3);
        t_div(16'd0, 2, 1);
        reg_write(1'b0, 32'h4000_0003);
        t_enable_gate();
        t_disable_mid();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule